// File: doc/BRIEF.md
# Data Read Path Controller

This block sequences a single data read once the core has issued a virtual address. It checks the alignment of the access, asks an external translation unit for the physical address, cache attributes and any permission fault. It then searches an external read buffer, a main data cache and a mini data cache, in that order. On a miss it can drain an external write buffer, allocate a line in one of the two caches, issue a soft flush for addresses in a dedicated flush window, or make an uncached read from memory. Words taken from a buffer or a cache are reduced to the requested byte or halfword according to the current endianness.

Each neighbour is reached through a request/acknowledge pair. A request stays high until the matching acknowledge, and only one neighbour is asked at a time. A new access is accepted only while the controller is idle. Completion is a one-cycle `done_o` pulse that carries the result and a fault code.

Top module: `rd_path_ctrl`

## Requirements
- R1: With `cfg_mmu_en_i` low, an access makes one memory read at the virtual address with the requested size and returns `mem_data_i` unchanged. No other neighbour is requested.
- R2: With `cfg_mmu_en_i` and `cfg_align_chk_i` high, a word access (size 2) with address bits [1:0] not zero, or a halfword access (size 1) with bit 0 set, completes with fault code 1 and data 0. No neighbour is requested. A byte access (size 0) never faults this way.
- R3: A non-zero `tlb_fault_i` at the translation acknowledge ends the access on the next cycle with that code and data 0. No further neighbour is requested.
- R4: After translation, the read buffer is searched first, then the main cache, then the mini cache, each with op 0 (lookup). The first hit supplies the word. A read buffer hit with a non-zero `rb_fault_i` returns that code and data 0.
- R5: On a miss with the physical address in [0xE0000000, 0xE8000000), no data is read and the result is 0 with no fault. If C is set, the main cache (B=1) or the mini cache (B=0) receives op 2 (flush). If C is clear, nothing is requested.
- R6: On a miss outside the window with B=1, the write buffer is drained before the fill or the memory read is requested.
- R7: On a miss outside the window with C=1 and `cfg_dcache_en_i` high, op 1 (fill) goes to the main cache when B=1 and to the mini cache when B=0. The returned word is lane-extracted.
- R8: Otherwise an uncached memory read is made at the physical address ORed with the virtual address bits [1:0] for bytes, bit 1 for halfwords and none for words. `mem_data_i` is returned unchanged.
- R9: For a halfword, the result is bits [15:0] of the word shifted right by ((big*2) XOR (VA & 2))*8. For a byte, the result is bits [7:0] of the word shifted right by ((big*3) XOR VA[1:0])*8. The upper bits are zero. Words pass unchanged.
- R10: `done_o` is high for exactly one cycle per access. At most one neighbour request is high in any cycle, and a request holds its address until acknowledged.
- R11: `req_valid_i` is ignored while an access is in progress. It neither changes the access nor produces an extra completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mmu_en_i | input | 1 | Translation enable |
| cfg_align_chk_i | input | 1 | Alignment checking enable |
| cfg_dcache_en_i | input | 1 | Data cache allocation enable |
| cfg_big_end_i | input | 1 | Big-endian lane selection |
| req_valid_i | input | 1 | Start an access (taken when idle) |
| req_va_i | input | AW | Virtual address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| tlb_req_o | output | 1 | Translation request |
| tlb_va_o | output | AW | Address to translate |
| tlb_ack_i | input | 1 | Translation response valid |
| tlb_fault_i | input | 3 | Translation/permission fault, 0 = none |
| tlb_pa_i | input | AW | Physical address |
| tlb_c_i | input | 1 | Cacheable attribute |
| tlb_b_i | input | 1 | Bufferable attribute |
| rb_req_o | output | 1 | Read buffer search request |
| rb_va_o | output | AW | Search address |
| rb_ack_i | input | 1 | Read buffer response valid |
| rb_hit_i | input | 1 | Read buffer hit |
| rb_fault_i | input | 3 | Fault stored with the hit entry |
| rb_data_i | input | 32 | Read buffer word |
| mc_req_o | output | 1 | Main cache request |
| nc_req_o | output | 1 | Mini cache request |
| cache_op_o | output | 2 | 0 lookup, 1 fill, 2 flush |
| cache_va_o | output | AW | Cache virtual address |
| cache_pa_o | output | AW | Cache physical address |
| mc_ack_i | input | 1 | Main cache response valid |
| mc_hit_i | input | 1 | Main cache lookup hit |
| mc_data_i | input | 32 | Main cache word |
| nc_ack_i | input | 1 | Mini cache response valid |
| nc_hit_i | input | 1 | Mini cache lookup hit |
| nc_data_i | input | 32 | Mini cache word |
| wb_drain_o | output | 1 | Write buffer drain request |
| wb_ack_i | input | 1 | Write buffer empty |
| mem_req_o | output | 1 | Uncached memory read request |
| mem_addr_o | output | AW | Memory address |
| mem_size_o | output | 2 | Memory access size |
| mem_ack_i | input | 1 | Memory response valid |
| mem_data_i | input | 32 | Memory data, already sized |
| done_o | output | 1 | Completion pulse |
| data_o | output | 32 | Result data |
| fault_o | output | 3 | Result fault code |

## Verification
The assertions assume that the four configuration inputs change only while the controller is idle. They also assume that every acknowledge is a single-cycle pulse given only to the neighbour whose request is high. The bench keeps to both. It changes configuration only between accesses, and a single responder acknowledges the one active request after a random delay of zero to two cycles. It lowers the acknowledge on the following cycle before any new request can be served. Random scenarios choose attributes, hits, faults and window addresses. Directed cases sweep every lane in both endian modes and inject a request while an access is in progress.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int DW = 32;
  localparam int FW = 3;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] OP_LOOK  = 2'd0;
  localparam logic [1:0] OP_FILL  = 2'd1;
  localparam logic [1:0] OP_FLUSH = 2'd2;

  localparam logic [FW-1:0] FLT_NONE  = 3'd0;
  localparam logic [FW-1:0] FLT_ALIGN = 3'd1;

  typedef enum logic [3:0] {
    S_IDLE, S_XLAT, S_RBUF, S_MAIN, S_MINI, S_DRAIN, S_FILL, S_FLUSH, S_MEM
  } st_e;
endpackage

// File: rtl/rpc_lane_sel.sv
module rpc_lane_sel
  import rpc_pkg::*;
(
  input  logic [DW-1:0] word_i,
  input  logic [1:0]    lo_i,
  input  logic [1:0]    size_i,
  input  logic          big_i,
  output logic [DW-1:0] val_o
);
  logic [1:0]    lane;
  logic [4:0]    sh;
  logic [DW-1:0] shifted;

  always_comb begin
    lane = 2'd0;
    if (size_i == SZ_HALF)      lane = {big_i ^ lo_i[1], 1'b0};
    else if (size_i == SZ_BYTE) lane = {big_i, big_i} ^ lo_i;
    sh      = {lane, 3'b000};
    shifted = word_i >> sh;
    case (size_i)
      SZ_HALF: val_o = {{(DW-16){1'b0}}, shifted[15:0]};
      SZ_BYTE: val_o = {{(DW-8){1'b0}}, shifted[7:0]};
      default: val_o = word_i;
    endcase
  end
endmodule

// File: rtl/rpc_miss_route.sv
module rpc_miss_route #(
  parameter int            AW     = 32,
  parameter logic [AW-1:0] WIN_LO = 32'hE000_0000,
  parameter logic [AW-1:0] WIN_HI = 32'hE800_0000
) (
  input  logic [AW-1:0] pa_i,
  input  logic          c_i,
  input  logic          b_i,
  input  logic          dcen_i,
  output logic          in_win_o,
  output logic          flush_o,
  output logic          drain_o,
  output logic          fill_o
);
  always_comb begin
    in_win_o = (pa_i >= WIN_LO) && (pa_i < WIN_HI);
    flush_o  = in_win_o && c_i;
    drain_o  = !in_win_o && b_i;
    fill_o   = !in_win_o && c_i && dcen_i;
  end
endmodule

// File: rtl/rd_path_ctrl.sv
module rd_path_ctrl
  import rpc_pkg::*;
#(
  parameter int            AW     = 32,
  parameter logic [AW-1:0] WIN_LO = 32'hE000_0000,
  parameter logic [AW-1:0] WIN_HI = 32'hE800_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_mmu_en_i,
  input  logic          cfg_align_chk_i,
  input  logic          cfg_dcache_en_i,
  input  logic          cfg_big_end_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_va_i,
  input  logic [1:0]    req_size_i,
  output logic          tlb_req_o,
  output logic [AW-1:0] tlb_va_o,
  input  logic          tlb_ack_i,
  input  logic [FW-1:0] tlb_fault_i,
  input  logic [AW-1:0] tlb_pa_i,
  input  logic          tlb_c_i,
  input  logic          tlb_b_i,
  output logic          rb_req_o,
  output logic [AW-1:0] rb_va_o,
  input  logic          rb_ack_i,
  input  logic          rb_hit_i,
  input  logic [FW-1:0] rb_fault_i,
  input  logic [DW-1:0] rb_data_i,
  output logic          mc_req_o,
  output logic          nc_req_o,
  output logic [1:0]    cache_op_o,
  output logic [AW-1:0] cache_va_o,
  output logic [AW-1:0] cache_pa_o,
  input  logic          mc_ack_i,
  input  logic          mc_hit_i,
  input  logic [DW-1:0] mc_data_i,
  input  logic          nc_ack_i,
  input  logic          nc_hit_i,
  input  logic [DW-1:0] nc_data_i,
  output logic          wb_drain_o,
  input  logic          wb_ack_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_data_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic [FW-1:0] fault_o
);
  st_e           st, nxt;
  logic [AW-1:0] va_q, pa_q;
  logic [1:0]    size_q;
  logic          raw_q, c_q, b_q;
  logic          done_q;
  logic [DW-1:0] data_q;
  logic [FW-1:0] fault_q;

  logic          fin, use_lane, misal;
  logic [FW-1:0] fin_flt;
  logic [DW-1:0] fin_word, lane_in, lane_out, fin_data;
  logic          in_win, do_flush, do_drain, do_fill;
  logic [AW-1:0] lo_mask;

  rpc_lane_sel u_lane (
    .word_i (lane_in),
    .lo_i   (va_q[1:0]),
    .size_i (size_q),
    .big_i  (cfg_big_end_i),
    .val_o  (lane_out)
  );

  rpc_miss_route #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_route (
    .pa_i     (pa_q),
    .c_i      (c_q),
    .b_i      (b_q),
    .dcen_i   (cfg_dcache_en_i),
    .in_win_o (in_win),
    .flush_o  (do_flush),
    .drain_o  (do_drain),
    .fill_o   (do_fill)
  );

  assign misal = cfg_align_chk_i &&
                 (((req_size_i == SZ_WORD) && (req_va_i[1:0] != 2'b00)) ||
                  ((req_size_i == SZ_HALF) && req_va_i[0]));

  always_comb begin
    case (st)
      S_RBUF:  lane_in = rb_data_i;
      S_MAIN:  lane_in = mc_data_i;
      S_MINI:  lane_in = nc_data_i;
      S_FILL:  lane_in = b_q ? mc_data_i : nc_data_i;
      default: lane_in = '0;
    endcase
  end

  always_comb begin
    nxt      = st;
    fin      = 1'b0;
    use_lane = 1'b0;
    fin_flt  = FLT_NONE;
    fin_word = '0;
    case (st)
      S_IDLE: if (req_valid_i) begin
        if (!cfg_mmu_en_i) nxt = S_MEM;
        else if (misal) begin fin = 1'b1; fin_flt = FLT_ALIGN; end
        else nxt = S_XLAT;
      end
      S_XLAT: if (tlb_ack_i) begin
        if (tlb_fault_i != FLT_NONE) begin fin = 1'b1; fin_flt = tlb_fault_i; end
        else nxt = S_RBUF;
      end
      S_RBUF: if (rb_ack_i) begin
        if (rb_hit_i) begin
          fin = 1'b1;
          fin_flt = rb_fault_i;
          use_lane = (rb_fault_i == FLT_NONE);
        end else nxt = S_MAIN;
      end
      S_MAIN: if (mc_ack_i) begin
        if (mc_hit_i) begin fin = 1'b1; use_lane = 1'b1; end
        else nxt = S_MINI;
      end
      S_MINI: if (nc_ack_i) begin
        if (nc_hit_i) begin fin = 1'b1; use_lane = 1'b1; end
        else if (in_win) begin
          if (do_flush) nxt = S_FLUSH;
          else fin = 1'b1;
        end
        else if (do_drain) nxt = S_DRAIN;
        else nxt = do_fill ? S_FILL : S_MEM;
      end
      S_DRAIN: if (wb_ack_i) nxt = do_fill ? S_FILL : S_MEM;
      S_FILL:  if (b_q ? mc_ack_i : nc_ack_i) begin fin = 1'b1; use_lane = 1'b1; end
      S_FLUSH: if (b_q ? mc_ack_i : nc_ack_i) fin = 1'b1;
      S_MEM:   if (mem_ack_i) begin fin = 1'b1; fin_word = mem_data_i; end
      default: nxt = S_IDLE;
    endcase
    if (fin) nxt = S_IDLE;
    fin_data = use_lane ? lane_out : fin_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= S_IDLE;
      va_q    <= '0;
      pa_q    <= '0;
      size_q  <= SZ_WORD;
      raw_q   <= 1'b0;
      c_q     <= 1'b0;
      b_q     <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      fault_q <= FLT_NONE;
    end else begin
      st     <= nxt;
      done_q <= fin;
      if (fin) begin
        data_q  <= fin_data;
        fault_q <= fin_flt;
      end
      if (st == S_IDLE && req_valid_i) begin
        va_q   <= req_va_i;
        size_q <= req_size_i;
        raw_q  <= !cfg_mmu_en_i;
      end
      if (st == S_XLAT && tlb_ack_i) begin
        pa_q <= tlb_pa_i;
        c_q  <= tlb_c_i;
        b_q  <= tlb_b_i;
      end
    end
  end

  always_comb begin
    case (size_q)
      SZ_BYTE: lo_mask = AW'(3);
      SZ_HALF: lo_mask = AW'(2);
      default: lo_mask = '0;
    endcase
  end

  assign tlb_req_o  = (st == S_XLAT);
  assign tlb_va_o   = va_q;
  assign rb_req_o   = (st == S_RBUF);
  assign rb_va_o    = va_q;
  assign mc_req_o   = (st == S_MAIN) || (b_q && (st == S_FILL || st == S_FLUSH));
  assign nc_req_o   = (st == S_MINI) || (!b_q && (st == S_FILL || st == S_FLUSH));
  assign cache_op_o = (st == S_FILL) ? OP_FILL : (st == S_FLUSH) ? OP_FLUSH : OP_LOOK;
  assign cache_va_o = va_q;
  assign cache_pa_o = pa_q;
  assign wb_drain_o = (st == S_DRAIN);
  assign mem_req_o  = (st == S_MEM);
  assign mem_addr_o = raw_q ? va_q : (pa_q | (va_q & lo_mask));
  assign mem_size_o = size_q;
  assign done_o     = done_q;
  assign data_o     = data_q;
  assign fault_o    = fault_q;
endmodule

// File: rtl/rd_path_ctrl_chk.sv
module rd_path_ctrl_chk
  import rpc_pkg::*;
#(
  parameter int            AW     = 32,
  parameter logic [AW-1:0] WIN_LO = 32'hE000_0000,
  parameter logic [AW-1:0] WIN_HI = 32'hE800_0000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_mmu_en_i,
  input logic          cfg_dcache_en_i,
  input logic          tlb_req_o,
  input logic          tlb_ack_i,
  input logic [FW-1:0] tlb_fault_i,
  input logic          rb_req_o,
  input logic          rb_ack_i,
  input logic          rb_hit_i,
  input logic [FW-1:0] rb_fault_i,
  input logic          mc_req_o,
  input logic          nc_req_o,
  input logic [1:0]    cache_op_o,
  input logic [AW-1:0] cache_pa_o,
  input logic          wb_drain_o,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          done_o,
  input logic [FW-1:0] fault_o
);
  AST_SINGLE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tlb_req_o, rb_req_o, mc_req_o, nc_req_o, wb_drain_o, mem_req_o})); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R10
  AST_RAW_NO_XLAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mmu_en_i |-> !tlb_req_o && !rb_req_o); // R1
  AST_XLAT_FAULT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_req_o && tlb_ack_i && tlb_fault_i != FLT_NONE
      |=> done_o && fault_o == $past(tlb_fault_i) && !rb_req_o); // R3
  AST_RB_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_req_o && rb_ack_i && rb_hit_i && rb_fault_i != FLT_NONE
      |=> done_o && fault_o == $past(rb_fault_i)); // R4
  AST_MAIN_AFTER_RB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mc_req_o) && cache_op_o == OP_LOOK |-> $past(rb_req_o)); // R4
  AST_FLUSH_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_req_o || nc_req_o) && cache_op_o == OP_FLUSH
      |-> cache_pa_o >= WIN_LO && cache_pa_o < WIN_HI); // R5
  AST_FILL_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_req_o || nc_req_o) && cache_op_o == OP_FILL |-> cfg_dcache_en_i); // R7
endmodule

bind rd_path_ctrl rd_path_ctrl_chk #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chk (.*);

// File: tb/rd_path_ctrl_test.sv
`timescale 1ns/1ps
module rd_path_ctrl_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n = 1'b0;

  logic mmu_en, align_chk, dcen, big;
  logic req_valid; logic [31:0] req_va; logic [1:0] req_size;
  logic tlb_req, rb_req, mc_req, nc_req, wb_drain, mem_req, done;
  logic [31:0] tlb_va, rb_va, cache_va, cache_pa, mem_addr, data;
  logic [1:0] cache_op, mem_size; logic [2:0] fault;
  logic tlb_ack = 0, rb_ack = 0, mc_ack = 0, nc_ack = 0, wb_ack = 0, mem_ack = 0;

  logic [2:0] s_tflt, s_rbflt; logic [31:0] s_pa, s_rbdata, s_mdata, s_ndata, s_fill, s_mem;
  logic s_c, s_b, s_rbhit, s_mhit, s_nhit;

  rd_path_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mmu_en_i(mmu_en), .cfg_align_chk_i(align_chk),
    .cfg_dcache_en_i(dcen), .cfg_big_end_i(big), .req_valid_i(req_valid), .req_va_i(req_va),
    .req_size_i(req_size), .tlb_req_o(tlb_req), .tlb_va_o(tlb_va), .tlb_ack_i(tlb_ack),
    .tlb_fault_i(s_tflt), .tlb_pa_i(s_pa), .tlb_c_i(s_c), .tlb_b_i(s_b), .rb_req_o(rb_req),
    .rb_va_o(rb_va), .rb_ack_i(rb_ack), .rb_hit_i(s_rbhit), .rb_fault_i(s_rbflt),
    .rb_data_i(s_rbdata), .mc_req_o(mc_req), .nc_req_o(nc_req), .cache_op_o(cache_op),
    .cache_va_o(cache_va), .cache_pa_o(cache_pa), .mc_ack_i(mc_ack), .mc_hit_i(s_mhit),
    .mc_data_i(cache_op == 2'd1 ? s_fill : s_mdata), .nc_ack_i(nc_ack), .nc_hit_i(s_nhit),
    .nc_data_i(cache_op == 2'd1 ? s_fill : s_ndata), .wb_drain_o(wb_drain), .wb_ack_i(wb_ack),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_size_o(mem_size), .mem_ack_i(mem_ack),
    .mem_data_i(s_mem), .done_o(done), .data_o(data), .fault_o(fault));

  // trace bits: 0 xlat,1 rbuf,2 main look,3 mini look,4 drain,5 main fill,6 mini fill,
  // 7 main flush,8 mini flush,9 mem
  logic [9:0] trace; logic [31:0] got_addr; logic [1:0] got_size; logic drained_first;
  int dly = 0;
  int checks = 0, errors = 0, cycles = 0;

  always @(negedge clk) begin
    if (tlb_ack | rb_ack | mc_ack | nc_ack | wb_ack | mem_ack) begin
      {tlb_ack, rb_ack, mc_ack, nc_ack, wb_ack, mem_ack} <= '0;
    end else if (tlb_req | rb_req | mc_req | nc_req | wb_drain | mem_req) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        dly <= int'($urandom % 3);
        if (tlb_req) begin tlb_ack <= 1; trace[0] <= 1; end
        if (rb_req)  begin rb_ack <= 1;  trace[1] <= 1; end
        if (wb_drain) begin wb_ack <= 1; trace[4] <= 1; end
        if (mc_req) begin
          mc_ack <= 1;
          if (cache_op == 2'd0) trace[2] <= 1;
          if (cache_op == 2'd1) begin trace[5] <= 1; drained_first <= trace[4]; end
          if (cache_op == 2'd2) trace[7] <= 1;
        end
        if (nc_req) begin
          nc_ack <= 1;
          if (cache_op == 2'd0) trace[3] <= 1;
          if (cache_op == 2'd1) begin trace[6] <= 1; drained_first <= trace[4]; end
          if (cache_op == 2'd2) trace[8] <= 1;
        end
        if (mem_req) begin
          mem_ack <= 1; trace[9] <= 1; got_addr <= mem_addr; got_size <= mem_size;
          drained_first <= trace[4];
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: act=%h exp=%h", tag, act, exp); end
  endtask

  function automatic logic [31:0] ext(logic [31:0] w, logic [1:0] lo, logic [1:0] sz, logic be);
    logic [1:0] ln;
    if (sz == 2'd2) return w;
    if (sz == 2'd1) return (lo[1] ^ be) ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    ln = lo ^ {be, be};
    case (ln)
      2'd0: return {24'h0, w[7:0]};
      2'd1: return {24'h0, w[15:8]};
      2'd2: return {24'h0, w[23:16]};
      default: return {24'h0, w[31:24]};
    endcase
  endfunction

  logic [2:0] e_fault; logic [31:0] e_data, e_addr; logic [9:0] e_trace; logic e_drain;

  task automatic model(input logic [31:0] va, input logic [1:0] sz);
    logic [31:0] m;
    e_fault = 0; e_data = 0; e_trace = 0; e_addr = 0; e_drain = 0;
    m = (sz == 2'd0) ? 32'd3 : (sz == 2'd1) ? 32'd2 : 32'd0;
    if (!mmu_en) begin e_trace = 10'h200; e_addr = va; e_data = s_mem; return; end
    if (align_chk && ((sz == 2'd2 && va[1:0] != 0) || (sz == 2'd1 && va[0]))) begin
      e_fault = 3'd1; return;
    end
    e_trace[0] = 1;
    if (s_tflt != 0) begin e_fault = s_tflt; return; end
    e_trace[1] = 1;
    if (s_rbhit) begin
      e_fault = s_rbflt; e_data = (s_rbflt != 0) ? 0 : ext(s_rbdata, va[1:0], sz, big); return;
    end
    e_trace[2] = 1;
    if (s_mhit) begin e_data = ext(s_mdata, va[1:0], sz, big); return; end
    e_trace[3] = 1;
    if (s_nhit) begin e_data = ext(s_ndata, va[1:0], sz, big); return; end
    if (s_pa[31:27] == 5'b11100) begin
      if (s_c) begin if (s_b) e_trace[7] = 1; else e_trace[8] = 1; end
      return;
    end
    e_trace[4] = s_b; e_drain = s_b;
    if (s_c && dcen) begin
      if (s_b) e_trace[5] = 1; else e_trace[6] = 1;
      e_data = ext(s_fill, va[1:0], sz, big);
    end else begin
      e_trace[9] = 1; e_addr = s_pa | (va & m); e_data = s_mem;
    end
  endtask

  task automatic run(input logic [31:0] va, input logic [1:0] sz, input string tag, input bit poke);
    int n = 0;
    trace = 0; drained_first = 0; got_addr = 0; got_size = 0;
    model(va, sz);
    @(negedge clk); req_valid = 1; req_va = va; req_size = sz;
    @(negedge clk); req_valid = poke; req_va = ~va; req_size = 2'd0;
    while (!done && n < 200) begin @(negedge clk); req_valid = 0; n++; end
    req_valid = 0;
    chk(done, {tag, " done"}, 32'(done), 1);
    chk(fault == e_fault, {tag, " fault"}, 32'(fault), 32'(e_fault));
    chk(data == e_data, {tag, " data"}, data, e_data);
    chk(trace == e_trace, {tag, " trace"}, 32'(trace), 32'(e_trace));
    if (e_trace[9]) begin
      chk(got_addr == e_addr, {tag, " R8 addr"}, got_addr, e_addr);
      chk(got_size == sz, {tag, " R8 size"}, 32'(got_size), 32'(sz));
    end
    if (e_trace[9:5] != 0 && mmu_en)
      chk(drained_first == e_drain, {tag, " R6 drain order"}, 32'(drained_first), 32'(e_drain));
    @(negedge clk);
    chk(!done, "R10 done single pulse", 32'(done), 0);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!done && !tlb_req, "R11 poke ignored", 32'({done, tlb_req}), 0);
      end
    end
  endtask

  task automatic scen(input logic [2:0] tf, input logic [31:0] pa, input logic c, input logic b,
                      input logic rbh, input logic mh, input logic nh);
    s_tflt = tf; s_pa = pa; s_c = c; s_b = b; s_rbhit = rbh; s_mhit = mh; s_nhit = nh;
    s_rbflt = 0;
  endtask

  initial begin
    mmu_en = 1; align_chk = 1; dcen = 1; big = 0;
    req_valid = 0; req_va = 0; req_size = 0;
    s_rbdata = 32'h1122_3344; s_mdata = 32'hA1A2_A3A4; s_ndata = 32'hB1B2_B3B4;
    s_fill = 32'hC1C2_C3C4; s_mem = 32'h0000_00D5;
    scen(0, 32'h1000_0000, 0, 0, 0, 0, 0);
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!done && !tlb_req && !mem_req && !mc_req && !nc_req, "reset idle",
        32'({done, tlb_req, mem_req, mc_req, nc_req}), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 translation off
    mmu_en = 0; run(32'h0000_1233, 2'd2, "R1 raw word", 0);
    run(32'h0000_4561, 2'd0, "R1 raw byte", 0);
    mmu_en = 1;
    // R2 alignment
    run(32'h0000_0102, 2'd2, "R2 word misaligned", 0);
    run(32'h0000_0101, 2'd1, "R2 half misaligned", 0);
    run(32'h0000_0103, 2'd0, "R2 byte never faults", 0);
    align_chk = 0; scen(0, 32'h1000_0000, 0, 0, 1, 0, 0);
    run(32'h0000_0102, 2'd2, "R2 check off", 0); align_chk = 1;
    // R3 translation fault
    scen(3'd5, 32'h1000_0000, 1, 1, 1, 1, 1); run(32'h0000_2000, 2'd2, "R3 xlat fault", 0);
    // R4 order and stored fault
    scen(0, 32'h1000_0000, 1, 1, 1, 1, 1); s_rbflt = 3'd6;
    run(32'h0000_2000, 2'd2, "R4 rb stored fault", 0);
    scen(0, 32'h1000_0000, 1, 1, 0, 1, 1); run(32'h0000_2000, 2'd2, "R4 main hit", 0);
    scen(0, 32'h1000_0000, 1, 1, 0, 0, 1); run(32'h0000_2000, 2'd2, "R4 mini hit", 0);
    // R5 window
    scen(0, 32'hE000_0000, 1, 1, 0, 0, 0); run(32'h0000_3000, 2'd2, "R5 flush main", 0);
    scen(0, 32'hE7FF_FFFC, 1, 0, 0, 0, 0); run(32'h0000_3000, 2'd2, "R5 flush mini", 0);
    scen(0, 32'hE400_0000, 0, 1, 0, 0, 0); run(32'h0000_3000, 2'd2, "R5 window uncached", 0);
    scen(0, 32'hE800_0000, 0, 0, 0, 0, 0); run(32'h0000_3001, 2'd0, "R8 just above window", 0);
    // R6 R7 R8
    scen(0, 32'h2000_0000, 1, 1, 0, 0, 0); run(32'h0000_3002, 2'd1, "R7 fill main R6", 0);
    scen(0, 32'h2000_0000, 1, 0, 0, 0, 0); run(32'h0000_3003, 2'd0, "R7 fill mini", 0);
    dcen = 0; scen(0, 32'h2000_0000, 1, 1, 0, 0, 0);
    run(32'h0000_3003, 2'd0, "R8 dcache off R6", 0); dcen = 1;
    scen(0, 32'h2000_0010, 0, 0, 0, 0, 0); run(32'h0000_3002, 2'd1, "R8 half uncached", 0);
    // R9 lane sweep both endians
    for (int e = 0; e < 2; e++) begin
      big = e[0];
      for (int a = 0; a < 4; a++) begin
        scen(0, 32'h1000_0000, 0, 0, 1, 0, 0);
        run(32'h0000_5000 | 32'(a), 2'd0, "R9 byte lane", 0);
        if (a[0] == 0) run(32'h0000_5000 | 32'(a), 2'd1, "R9 half lane", 0);
      end
    end
    big = 0;
    // R11 request while busy
    scen(0, 32'h2000_0000, 0, 1, 0, 0, 0); run(32'h0000_6000, 2'd2, "R11 busy", 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] va; logic [1:0] sz;
      mmu_en = ($urandom % 8) != 0; align_chk = $urandom % 2; dcen = ($urandom % 4) != 0;
      big = $urandom % 2;
      s_tflt = (($urandom % 8) == 0) ? 3'(2 + $urandom % 6) : 3'd0;
      s_pa = $urandom; if (($urandom % 5) == 0) s_pa[31:27] = 5'b11100;
      s_c = $urandom % 2; s_b = $urandom % 2;
      s_rbhit = ($urandom % 5) == 0; s_rbflt = (($urandom % 4) == 0) ? 3'(2 + $urandom % 6) : 3'd0;
      s_mhit = ($urandom % 4) == 0; s_nhit = ($urandom % 4) == 0;
      s_rbdata = $urandom; s_mdata = $urandom; s_ndata = $urandom; s_fill = $urandom; s_mem = $urandom;
      va = $urandom; sz = 2'($urandom % 3);
      run(va, sz, "R4 R9 random", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule